// File: doc/BRIEF.md
# Banked GPIO Edge-Interrupt Controller

The block drives and samples 32 general-purpose lines. The lines are grouped into four ports of eight pins, so line n is pin n%8 of port n/8. Software sets a direction and an output value for each line, and reads back each line's synchronised input level. Every line can report rising edges, falling edges or both into a per-port pending byte. Software clears pending bits by writing ones to them. One interrupt output, high while any bit is pending, goes to the CPU.

Access is through a 32-bit register port. It has a word address, a write strobe and four byte enables. Reads are combinational and have no side effects. Seven words fill a 0x1C-byte window.

In the one-bit-per-line words, port p sits in byte lane 3-p. In the two-bit-per-line mask words, port p's half-word sits at byte offset 2*p of the mask area. Port 0 is therefore always in the most significant lane.

Top module: `gpio_edge_irq`

## Requirements
- R1: After reset, every register reads zero, `gpio_o` and `gpio_oe_o` are zero, and `irq_o` is low.
- R2: Word 0 (direction, 1 = drive) and word 1 (output value) are read/write. Port p occupies bits [8*(3-p)+7 : 8*(3-p)], and pin k is bit 8*(3-p)+k. Byte enable `be_i[3-p]` gates the write of port p. `gpio_oe_o` follows word 0 and `gpio_o` follows word 1, indexed by line.
- R3: Word 2 returns each input after a two-flop synchroniser. A change at `gpio_i` is visible after two rising clock edges and not after one. Writes to word 2 have no effect.
- R4: Words 4 and 5 hold a 2-bit mode field per line. Word 4 holds port 0 in bits [31:16] and port 1 in bits [15:0]. Word 5 holds port 2 in bits [31:16] and port 3 in bits [15:0]. Pin k uses bits [2k+1:2k] of its port's half. The codes are 00 off, 01 falling edge, 10 rising edge and 11 both edges.
- R5: An input transition that matches a line's mode sets that line's bit in word 3, which uses the same lane layout as R2. `irq_o` goes high after the third rising clock edge following the input change, and not before.
- R6: A line whose mode field is 00 never sets its pending bit, whatever its input does.
- R7: Writing word 3 clears each bit written as 1 in an enabled byte lane. Bits written as 0, and lanes whose enable is low, are unchanged. Pending bits hold when there is no write and no edge.
- R8: If a matching edge and a clearing write hit the same line in the same cycle, the bit ends up set.
- R9: `irq_o` is high exactly when at least one pending bit is set.
- R10: Word 6 reads zero and ignores writes. Word address 7 also reads zero.
- R11: Each mode-word byte lane writes only its own four fields. Lane 3 and lane 1 carry pins 7..4, and lane 2 and lane 0 carry pins 3..0, of the port in that half.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Word address (byte offset / 4) |
| be_i | input | 4 | Byte enables for writes |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i`, combinational |
| gpio_i | input | 32 | Line inputs, line-indexed |
| gpio_o | output | 32 | Line output values |
| gpio_oe_o | output | 32 | Line drive enables |
| irq_o | output | 1 | Combined interrupt request |

## Verification
Directed cases pin down the cycle timing. Each latency is checked one edge early as well as on time: synchroniser latency on the input word, and the three-edge delay from an input change to `irq_o`. Another directed case places a falling edge in the same cycle as a clear of that line, which separates set-priority from clear-priority.

Random phases mix several kinds of operation:
- single input toggles and bursts of simultaneous toggles, against random mode fields, which separate rising, falling, both-edge and disabled lines;
- writes with random byte enables, which expose any crossed byte lanes or reversed port order;
- partial clears of pending bits.

After every operation, all seven words are compared with a bench model, along with the pins and the interrupt output.

// File: rtl/gpio_edge_pkg.sv
package gpio_edge_pkg;
  parameter int NPORT  = 4;
  parameter int PW     = 8;
  localparam int NLINE = NPORT * PW;
  localparam int BUS_W = 32;
  localparam int BE_W  = BUS_W / 8;
  localparam int AW    = 3;

  typedef enum logic [AW-1:0] {
    W_DIR   = 3'd0,
    W_DOUT  = 3'd1,
    W_DIN   = 3'd2,
    W_STAT  = 3'd3,
    W_MASK0 = 3'd4,
    W_MASK1 = 3'd5,
    W_RSVD  = 3'd6,
    W_NONE  = 3'd7
  } reg_word_e;

  typedef enum logic [1:0] {
    IRQ_OFF  = 2'b00,
    IRQ_FALL = 2'b01,
    IRQ_RISE = 2'b10,
    IRQ_BOTH = 2'b11
  } irq_mode_e;

  // line-indexed vector to bus word, port 0 in the top lane
  function automatic logic [BUS_W-1:0] to_bus(input logic [NLINE-1:0] v);
    logic [BUS_W-1:0] r;
    r = '0;
    for (int p = 0; p < NPORT; p++) r[(NPORT-1-p)*PW +: PW] = v[p*PW +: PW];
    return r;
  endfunction
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/gpio_edge_port.sv
module gpio_edge_port #(
  parameter int PW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [PW-1:0] sync_i,
  input  logic [2*PW-1:0] mode_i,
  input  logic [PW-1:0] clr_i,
  output logic [PW-1:0] stat_o,
  output logic [PW-1:0] rise_o,
  output logic [PW-1:0] fall_o
);
  logic [PW-1:0] prev_q, stat_q, hit;

  assign rise_o = sync_i & ~prev_q;
  assign fall_o = ~sync_i & prev_q;

  for (genvar k = 0; k < PW; k++) begin : g_pin
    // mode bit 1 selects rising, bit 0 selects falling
    assign hit[k] = (rise_o[k] & mode_i[2*k+1]) | (fall_o[k] & mode_i[2*k]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= '0;
      stat_q <= '0;
    end else begin
      prev_q <= sync_i;
      stat_q <= (stat_q & ~clr_i) | hit;  // set wins
    end
  end

  assign stat_o = stat_q;
endmodule

// File: rtl/gpio_edge_irq.sv
module gpio_edge_irq
  import gpio_edge_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [BE_W-1:0]  be_i,
  input  logic [BUS_W-1:0] wdata_i,
  output logic [BUS_W-1:0] rdata_o,
  input  logic [NLINE-1:0] gpio_i,
  output logic [NLINE-1:0] gpio_o,
  output logic [NLINE-1:0] gpio_oe_o,
  output logic             irq_o
);
  localparam int HW = 2 * PW;

  logic [NLINE-1:0]   dir_q, dout_q, sync_w, stat_q, rise_w, fall_w, clr_w;
  logic [2*NLINE-1:0] mask_q;
  reg_word_e          wsel;

  assign wsel = reg_word_e'(addr_i);

  gpio_sync #(.W(NLINE)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (gpio_i),
    .q_o   (sync_w)
  );

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    localparam int        LN = NPORT - 1 - p;
    localparam int        MH = (p % 2 == 0) ? 3 : 1;
    localparam reg_word_e MW = (p / 2 == 0) ? W_MASK0 : W_MASK1;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        dir_q[p*PW +: PW]  <= '0;
        dout_q[p*PW +: PW] <= '0;
        mask_q[p*HW +: HW] <= '0;
      end else if (wr_en_i) begin
        if (wsel == W_DIR && be_i[LN])  dir_q[p*PW +: PW]  <= wdata_i[LN*8 +: PW];
        if (wsel == W_DOUT && be_i[LN]) dout_q[p*PW +: PW] <= wdata_i[LN*8 +: PW];
        if (wsel == MW) begin
          if (be_i[MH])   mask_q[p*HW+PW +: PW] <= wdata_i[MH*8 +: PW];
          if (be_i[MH-1]) mask_q[p*HW +: PW]    <= wdata_i[(MH-1)*8 +: PW];
        end
      end
    end

    assign clr_w[p*PW +: PW] = (wr_en_i && wsel == W_STAT && be_i[LN]) ?
                               wdata_i[LN*8 +: PW] : '0;

    gpio_edge_port #(.PW(PW)) u_port (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .sync_i(sync_w[p*PW +: PW]),
      .mode_i(mask_q[p*HW +: HW]),
      .clr_i (clr_w[p*PW +: PW]),
      .stat_o(stat_q[p*PW +: PW]),
      .rise_o(rise_w[p*PW +: PW]),
      .fall_o(fall_w[p*PW +: PW])
    );
  end

  always_comb begin
    unique case (wsel)
      W_DIR:   rdata_o = to_bus(dir_q);
      W_DOUT:  rdata_o = to_bus(dout_q);
      W_DIN:   rdata_o = to_bus(sync_w);
      W_STAT:  rdata_o = to_bus(stat_q);
      W_MASK0: rdata_o = {mask_q[0*HW +: HW], mask_q[1*HW +: HW]};
      W_MASK1: rdata_o = {mask_q[2*HW +: HW], mask_q[3*HW +: HW]};
      default: rdata_o = '0;
    endcase
  end

  assign gpio_o    = dout_q;
  assign gpio_oe_o = dir_q;
  assign irq_o     = |stat_q;
endmodule

// File: rtl/gpio_edge_irq_chk.sv
module gpio_edge_irq_chk
  import gpio_edge_pkg::*;
(
  input logic               clk_i,
  input logic               rst_ni,
  input logic               wr_en_i,
  input logic [AW-1:0]      addr_i,
  input logic [NLINE-1:0]   gpio_oe_o,
  input logic               irq_o,
  input logic [NLINE-1:0]   stat_q,
  input logic [NLINE-1:0]   rise_w,
  input logic [NLINE-1:0]   fall_w,
  input logic [2*NLINE-1:0] mask_q
);
  logic [NLINE-1:0] en_w, hit_w;
  for (genvar n = 0; n < NLINE; n++) begin : g_ln
    assign en_w[n]  = mask_q[2*n] | mask_q[2*n+1];
    assign hit_w[n] = (rise_w[n] && mask_q[2*n+1]) || (fall_w[n] && mask_q[2*n]);
  end

  p_oe_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_en_i && addr_i == W_DIR) |=> $stable(gpio_oe_o));

  p_irq_src_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past(|(rise_w | fall_w)));

  p_off_no_set_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((stat_q & ~$past(stat_q) & ~$past(en_w)) == '0));

  p_stat_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!(wr_en_i && addr_i == W_STAT) && (rise_w | fall_w) == '0) |=> $stable(stat_q));

  p_set_wins_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (($past(hit_w) & ~stat_q) == '0));

  p_irq_low_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_o |-> (stat_q == '0));
endmodule

bind gpio_edge_irq gpio_edge_irq_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .wr_en_i  (wr_en_i),
  .addr_i   (addr_i),
  .gpio_oe_o(gpio_oe_o),
  .irq_o    (irq_o),
  .stat_q   (stat_q),
  .rise_w   (rise_w),
  .fall_w   (fall_w),
  .mask_q   (mask_q)
);

// File: tb/gpio_edge_irq_bench.sv
`timescale 1ns/1ps
module gpio_edge_irq_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  addr = '0;
  logic [3:0]  be = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [31:0] gin = '0;
  logic [31:0] gout, goe;
  logic        irq;

  int checks = 0;
  int errors = 0;

  logic [31:0] dir_m = '0, dout_m = '0, stat_m = '0;
  logic [63:0] mask_m = '0;

  always #4 clk = ~clk;

  gpio_edge_irq u_gpio_edge_irq (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .addr_i(addr), .be_i(be),
    .wdata_i(wdata), .rdata_o(rdata), .gpio_i(gin), .gpio_o(gout),
    .gpio_oe_o(goe), .irq_o(irq)
  );

  function automatic logic [31:0] pack_w(input logic [31:0] v);
    logic [31:0] r;
    for (int p = 0; p < 4; p++)
      for (int k = 0; k < 8; k++) r[8*(3-p)+k] = v[8*p+k];
    return r;
  endfunction

  function automatic logic [31:0] merge_l(input logic [31:0] old, input logic [31:0] w,
                                          input logic [3:0] b);
    logic [31:0] r;
    r = old;
    for (int p = 0; p < 4; p++) if (b[3-p]) r[8*p +: 8] = w[8*(3-p) +: 8];
    return r;
  endfunction

  function automatic logic [31:0] mask_word(input int wi);
    return {mask_m[32*wi +: 16], mask_m[32*wi+16 +: 16]};
  endfunction

  function automatic logic [31:0] edge_hits(input logic [31:0] o, input logic [31:0] n,
                                            input logic [63:0] m);
    logic [31:0] r;
    r = '0;
    for (int i = 0; i < 32; i++) begin
      if (!o[i] && n[i] && (m[2*i +: 2] == 2'b10 || m[2*i +: 2] == 2'b11)) r[i] = 1'b1;
      if (o[i] && !n[i] && (m[2*i +: 2] == 2'b01 || m[2*i +: 2] == 2'b11)) r[i] = 1'b1;
    end
    return r;
  endfunction

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h exp %h", tag, got, exp);
    end
  endtask

  task automatic bus_wr(input logic [2:0] a, input logic [3:0] b, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; be = b; wdata = d;
    @(negedge clk);
    wr_en = 1'b0; be = '0;
    case (a)
      3'd0: dir_m = merge_l(dir_m, d, b);
      3'd1: dout_m = merge_l(dout_m, d, b);
      3'd3: stat_m = stat_m & ~merge_l('0, d, b);
      3'd4, 3'd5: begin
        for (int l = 0; l < 4; l++)
          if (b[l]) mask_m[16*(2*(a-4) + (l >= 2 ? 0 : 1)) + 8*(l%2) +: 8] = d[8*l +: 8];
      end
      default: ;
    endcase
  endtask

  task automatic bus_rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic check_all();
    logic [31:0] d;
    bus_rd(3'd0, d); chk("R2 dir word", d, pack_w(dir_m));
    bus_rd(3'd1, d); chk("R2 dout word", d, pack_w(dout_m));
    bus_rd(3'd2, d); chk("R3 din word", d, pack_w(gin));
    bus_rd(3'd3, d); chk("R5 R7 status word", d, pack_w(stat_m));
    bus_rd(3'd4, d); chk("R4 R11 mode word 0", d, mask_word(0));
    bus_rd(3'd5, d); chk("R4 R11 mode word 1", d, mask_word(1));
    bus_rd(3'd6, d); chk("R10 reserved word", d, '0);
    chk("R2 gpio_oe_o", goe, dir_m);
    chk("R2 gpio_o", gout, dout_m);
    chk("R9 irq_o", {31'd0, irq}, {31'd0, stat_m != '0});
  endtask

  task automatic toggle(input logic [31:0] x);
    logic [31:0] o;
    o = gin;
    @(negedge clk);
    gin = gin ^ x;
    repeat (4) @(negedge clk);
    stat_m = stat_m | edge_hits(o, gin, mask_m);
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'd20817));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R1 irq after reset", {31'd0, irq}, '0);
    chk("R1 gpio_o after reset", gout, '0);
    chk("R1 gpio_oe_o after reset", goe, '0);
    for (int a = 0; a < 8; a++) begin
      bus_rd(a[2:0], d); chk("R1 word after reset", d, '0);
    end

    // R3 synchroniser latency, line 5 = port 0 pin 5 = bus bit 29
    @(negedge clk); gin[5] = 1'b1;
    @(negedge clk); addr = 3'd2; #1 chk("R3 din one edge", {31'd0, rdata[29]}, '0);
    @(negedge clk); #1 chk("R3 din two edges", {31'd0, rdata[29]}, 32'd1);
    repeat (2) @(negedge clk);
    chk("R6 no set with mode off", {31'd0, irq}, '0);
    bus_wr(3'd2, 4'hF, 32'hFFFF_FFFF);
    bus_rd(3'd2, d); chk("R3 din write ignored", d, pack_w(gin));

    // R5 latency, line 9 = port 1 pin 1, rising (10) at word 4 bits [3:2]
    bus_wr(3'd4, 4'b0001, 32'h0000_0008);
    @(negedge clk); gin[9] = 1'b1;
    @(negedge clk); #1 chk("R5 irq one edge", {31'd0, irq}, '0);
    @(negedge clk); #1 chk("R5 irq two edges", {31'd0, irq}, '0);
    @(negedge clk); #1 chk("R5 irq three edges", {31'd0, irq}, 32'd1);
    stat_m[9] = 1'b1;
    check_all();

    // R8 falling edge set coincides with clear of line 9 (bus bit 17)
    bus_wr(3'd4, 4'b0001, 32'h0000_000C);
    @(negedge clk); gin[9] = 1'b0;
    @(negedge clk);
    @(negedge clk); wr_en = 1'b1; addr = 3'd3; be = 4'b0100; wdata = 32'h0002_0000;
    @(negedge clk); wr_en = 1'b0; be = '0;
    bus_rd(3'd3, d); chk("R8 set wins over clear", {31'd0, d[17]}, 32'd1);
    bus_wr(3'd3, 4'b0100, 32'h0002_0000);
    bus_rd(3'd3, d); chk("R7 clear with no edge", {31'd0, d[17]}, '0);

    // R10 reserved and unused addresses
    bus_wr(3'd6, 4'hF, 32'hFFFF_FFFF);
    bus_rd(3'd7, d); chk("R10 word 7 reads zero", d, '0);
    check_all();

    for (int it = 0; it < 400; it++) begin
      case ($urandom_range(0, 5))
        0: bus_wr(3'd0, 4'($urandom), $urandom);
        1: bus_wr(3'd1, 4'($urandom), $urandom);
        2: bus_wr(3'($urandom_range(4, 5)), 4'($urandom), $urandom);
        3: toggle(32'd1 << $urandom_range(0, 31));
        4: toggle($urandom);
        default: bus_wr(3'd3, 4'($urandom), $urandom);
      endcase
      check_all();
    end

    bus_wr(3'd3, 4'hF, 32'hFFFF_FFFF);
    chk("R7 R9 full clear", {31'd0, irq}, '0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule